// File: doc/BRIEF.md
# Data Cache Maintenance Operation Controller

This block carries out the software cache maintenance and inspection operations of an 8-way, 32-set data cache. It holds the per-line tag, valid and dirty state and a 10-bit replacement-order word for each set. Operations come in through one issue port, one per cycle. Each operation supplies a base register value and a signed 7-bit word offset. The block forms the target address and then does one of four things: writes a dirty block back, drops a block, returns one line's tag, or returns a set's dirty and ordering bits.

While an operation is in progress, the block holds the CPU stall output high for the number of cycles that operation needs. A dirty block goes out over a request/acknowledge port to memory. The normal access path installs lines through a fill port, and each fill makes its way the most recently used way of the set.

Top module: `dcm_ctrl`

## Requirements
- R1: The target address is `op_base + 4*sign_extend(op_ofs)`. Bits [31:11] form the tag, bits [10:6] the set and bits [13:11] the way for read-tag. A 64-byte block is addressed by bits [5:0].
- R2: Copyback (`op_code`=0) that misses, meaning no valid way of the set matches the tag, raises no stall and changes no state.
- R3: Copyback that hits a clean line stalls exactly 4 cycles. The line stays valid and clean.
- R4: Copyback that hits a dirty line raises `wb_req` with `wb_addr` = {tag, set, 6'b0}. The request holds until `wb_ack`. The stall lasts at least 19 cycles and does not end before the acknowledge. Afterwards the line is valid and clean.
- R5: Invalidate (`op_code`=1) that hits clears valid and dirty, never requests a writeback, and stalls 2 cycles. A miss stalls 0 cycles.
- R6: A copyback or invalidate hit makes the way least recently used. Ordering word: bit p (p=0..3) set means way 2p+1 is older than way 2p. Bits 4..9 order the pairs (0,1),(0,2),(0,3),(1,2),(1,3),(2,3), and a bit set means the lower-numbered pair is older.
- R7: Read-tag (`op_code`=2) raises no stall. In the next cycle it pulses `rd_valid` with `rd_data` = {10'b0, valid, tag[20:0]} of the addressed set and way.
- R8: Read-status (`op_code`=3) stalls 1 cycle. In that cycle `rd_valid` is high and `rd_data` = {14'b0, dirty[7:0] (bit w = way w), order[9:0]}.
- R9: An operation presented while `stall` is high is ignored.
- R10: A fill writes the tag, sets valid, sets dirty to `fill_dirty`, and makes the way most recently used. When a fill and an operation share a cycle, the operation looks up and reads the contents as they were before the fill, and its own updates override the fill's.
- R11: After reset all lines are invalid and clean, every ordering word is zero, and `stall`, `wb_req` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Maintenance operation presented |
| op_code | input | 2 | 0 copyback, 1 invalidate, 2 read-tag, 3 read-status |
| op_base | input | 32 | Base register value |
| op_ofs | input | 7 | Signed word offset |
| stall | output | 1 | CPU stall |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read-tag or read-status result |
| wb_req | output | 1 | Block writeback request |
| wb_addr | output | 32 | Block writeback address |
| wb_ack | input | 1 | Writeback accepted by memory |
| fill_valid | input | 1 | Line install from the access path |
| fill_set | input | 5 | Set to install |
| fill_way | input | 3 | Way to install |
| fill_tag | input | 21 | Tag to install |
| fill_dirty | input | 1 | Dirty state of the installed line |

## Verification
A line install from the access path and a maintenance operation on the same set can land in the same cycle. The bench provokes this by driving a fill and an operation together on one edge. In the first case the fill installs a new tag in a way that an invalidate hits through its old tag. In the second case a read-tag addresses the way being filled. The reference model settles the expected outcome from the pre-fill lookup and from the rule that the operation's update overrides the fill's, and both cases are confirmed by later read-tag results.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    parameter int ADDR_W    = 32;
    parameter int OFS_W     = 7;
    parameter int LINE_LOG2 = 6;
    parameter int SET_LOG2  = 5;
    parameter int WAY_LOG2  = 3;
    parameter int LRU_W     = 10;
    parameter int WB_MIN    = 19;
    parameter int CB_CLEAN  = 4;
    parameter int INV_HIT   = 2;
    parameter int STAT_CYC  = 1;

    localparam int NSETS  = 1 << SET_LOG2;
    localparam int NWAYS  = 1 << WAY_LOG2;
    localparam int TAG_W  = ADDR_W - LINE_LOG2 - SET_LOG2;
    localparam int NPAIRS = NWAYS / 2;
    localparam int CNT_W  = $clog2(WB_MIN + 1);

    typedef enum logic [1:0] {
        OP_COPYBACK = 2'd0,
        OP_INVAL    = 2'd1,
        OP_RDTAG    = 2'd2,
        OP_RDSTAT   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_WB    = 2'd2
    } fsm_e;

    // Move one way to the oldest (make_old=1) or newest position of its set.
    function automatic logic [LRU_W-1:0] order_mark(input logic [LRU_W-1:0] cur,
                                                    input logic [WAY_LOG2-1:0] way,
                                                    input logic make_old);
        logic [LRU_W-1:0] v;
        int k;
        int p;
        v = cur;
        p = int'(way[WAY_LOG2-1:1]);
        v[p] = make_old ? way[0] : ~way[0];
        k = 0;
        for (int a = 0; a < NPAIRS; a++) begin
            for (int b = a + 1; b < NPAIRS; b++) begin
                if (a == p)      v[NPAIRS + k] = make_old;
                else if (b == p) v[NPAIRS + k] = ~make_old;
                k++;
            end
        end
        return v;
    endfunction
endpackage

// File: rtl/dcm_addr_gen.sv
module dcm_addr_gen
    import dcm_pkg::*;
(
    input  logic [ADDR_W-1:0]   base,
    input  logic [OFS_W-1:0]    ofs,
    output logic [SET_LOG2-1:0] set_idx,
    output logic [WAY_LOG2-1:0] way_idx,
    output logic [TAG_W-1:0]    tag
);
    localparam int EXT_W = ADDR_W - OFS_W - 2;

    logic [ADDR_W-1:0] target;

    always_comb begin
        target  = base + {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
        set_idx = target[LINE_LOG2 +: SET_LOG2];
        way_idx = target[LINE_LOG2 + SET_LOG2 +: WAY_LOG2];
        tag     = target[ADDR_W-1 -: TAG_W];
    end
endmodule

// File: rtl/dcm_tag_match.sv
module dcm_tag_match
    import dcm_pkg::*;
(
    input  logic [NWAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [NWAYS-1:0]            row_vld,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_LOG2-1:0]         hit_way
);
    logic [NWAYS-1:0] match;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign match[w] = row_vld[w] && (row_tag[w] == tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_LOG2'(w);
        end
    end
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
    import dcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic [ADDR_W-1:0]   op_base,
    input  logic [OFS_W-1:0]    op_ofs,
    output logic                stall,
    output logic                rd_valid,
    output logic [31:0]         rd_data,
    output logic                wb_req,
    output logic [ADDR_W-1:0]   wb_addr,
    input  logic                wb_ack,
    input  logic                fill_valid,
    input  logic [SET_LOG2-1:0] fill_set,
    input  logic [WAY_LOG2-1:0] fill_way,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic                fill_dirty
);
    typedef struct packed {
        logic [NSETS-1:0][NWAYS-1:0][TAG_W-1:0] tag;
        logic [NSETS-1:0][NWAYS-1:0]            vld;
        logic [NSETS-1:0][NWAYS-1:0]            dty;
        logic [NSETS-1:0][LRU_W-1:0]            lru;
        fsm_e                                   fsm;
        logic [CNT_W-1:0]                       cnt;
        logic                                   acked;
        logic [SET_LOG2-1:0]                    wb_set;
        logic [WAY_LOG2-1:0]                    wb_way;
        logic                                   wb_req;
        logic [ADDR_W-1:0]                      wb_addr;
        logic                                   rd_valid;
        logic [31:0]                            rd_data;
    } state_t;

    state_t q, d;

    logic [SET_LOG2-1:0] lk_set;
    logic [WAY_LOG2-1:0] lk_way;
    logic [TAG_W-1:0]    lk_tag;
    logic                lk_hit;
    logic [WAY_LOG2-1:0] lk_hit_way;
    logic                accept;
    logic                ack_now;

    dcm_addr_gen i_addr (
        .base    (op_base),
        .ofs     (op_ofs),
        .set_idx (lk_set),
        .way_idx (lk_way),
        .tag     (lk_tag)
    );

    dcm_tag_match i_match (
        .row_tag (q.tag[lk_set]),
        .row_vld (q.vld[lk_set]),
        .tag     (lk_tag),
        .hit     (lk_hit),
        .hit_way (lk_hit_way)
    );

    assign accept  = op_valid && (q.fsm == ST_IDLE);
    assign ack_now = q.wb_req && wb_ack;

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        d.rd_data  = '0;

        // access-path install first; a same-cycle operation overrides it
        if (fill_valid) begin
            d.tag[fill_set][fill_way] = fill_tag;
            d.vld[fill_set][fill_way] = 1'b1;
            d.dty[fill_set][fill_way] = fill_dirty;
            d.lru[fill_set] = order_mark(d.lru[fill_set], fill_way, 1'b0);
        end

        unique case (q.fsm)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op_e'(op_code))
                        OP_COPYBACK: begin
                            if (lk_hit) begin
                                d.lru[lk_set] = order_mark(d.lru[lk_set], lk_hit_way, 1'b1);
                                if (q.dty[lk_set][lk_hit_way]) begin
                                    d.fsm     = ST_WB;
                                    d.cnt     = CNT_W'(WB_MIN);
                                    d.acked   = 1'b0;
                                    d.wb_req  = 1'b1;
                                    d.wb_addr = {lk_tag, lk_set, {LINE_LOG2{1'b0}}};
                                    d.wb_set  = lk_set;
                                    d.wb_way  = lk_hit_way;
                                end else begin
                                    d.fsm = ST_STALL;
                                    d.cnt = CNT_W'(CB_CLEAN);
                                end
                            end
                        end
                        OP_INVAL: begin
                            if (lk_hit) begin
                                d.vld[lk_set][lk_hit_way] = 1'b0;
                                d.dty[lk_set][lk_hit_way] = 1'b0;
                                d.lru[lk_set] = order_mark(d.lru[lk_set], lk_hit_way, 1'b1);
                                d.fsm = ST_STALL;
                                d.cnt = CNT_W'(INV_HIT);
                            end
                        end
                        OP_RDTAG: begin
                            d.rd_valid               = 1'b1;
                            d.rd_data[TAG_W-1:0]     = q.tag[lk_set][lk_way];
                            d.rd_data[TAG_W]         = q.vld[lk_set][lk_way];
                        end
                        OP_RDSTAT: begin
                            d.rd_valid                        = 1'b1;
                            d.rd_data[LRU_W-1:0]              = q.lru[lk_set];
                            d.rd_data[LRU_W +: NWAYS]         = q.dty[lk_set];
                            d.fsm = ST_STALL;
                            d.cnt = CNT_W'(STAT_CYC);
                        end
                        default: ;
                    endcase
                end
            end
            ST_STALL: begin
                if (q.cnt == CNT_W'(1)) d.fsm = ST_IDLE;
                else                    d.cnt = q.cnt - CNT_W'(1);
            end
            ST_WB: begin
                if (ack_now) begin
                    d.wb_req = 1'b0;
                    d.acked  = 1'b1;
                    d.dty[q.wb_set][q.wb_way] = 1'b0;
                end
                if (q.cnt == CNT_W'(1)) begin
                    if (q.acked || ack_now) d.fsm = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stall    = (q.fsm != ST_IDLE);
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign wb_req   = q.wb_req;
    assign wb_addr  = q.wb_addr;

    // R4
    wb_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R4
    wb_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> stall);

    // R5
    inval_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_INVAL) |=> !wb_req);

    // R8
    rdstat_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_RDSTAT) |=> (stall && rd_valid));

    // R6
    lru_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_INVAL && lk_hit) |=>
        (q.lru[$past(lk_set)][$past(lk_hit_way[WAY_LOG2-1:1])] == $past(lk_hit_way[0])));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && op_valid && !rd_valid) |=> !rd_valid);
endmodule

// File: tb/test_dcm_ctrl.sv
`timescale 1ns/1ps
module test_dcm_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [31:0] op_base = '0;
    logic [6:0]  op_ofs = '0;
    logic        stall, rd_valid, wb_req;
    logic [31:0] rd_data, wb_addr;
    logic        wb_ack = 1'b0;
    logic        fill_valid = 1'b0;
    logic [4:0]  fill_set = '0;
    logic [2:0]  fill_way = '0;
    logic [20:0] fill_tag = '0;
    logic        fill_dirty = 1'b0;

    int tests = 0, fails = 0, ack_delay = 0, ack_cnt = 0;
    bit finished = 0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    dcm_ctrl i_dcm_ctrl (.*);

    // ---------------- reference model ----------------
    logic [20:0] mtag [32][8];
    bit          mvld [32][8];
    bit          mdty [32][8];
    logic [9:0]  mlru [32];
    int  m_left, m_cnt, m_wset, m_wway;
    bit  m_inwb, m_acked, m_req, m_rv;
    logic [31:0] m_waddr, m_rd;

    function automatic logic [9:0] ref_order(logic [9:0] v, int w, bit old);
        int pa [6] = '{0, 0, 0, 1, 1, 2};
        int pb [6] = '{1, 2, 3, 2, 3, 3};
        int p = w / 2;
        v[p] = old ? w[0] : !w[0];
        for (int k = 0; k < 6; k++) begin
            if (pa[k] == p) v[4 + k] = old;
            if (pb[k] == p) v[4 + k] = !old;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 32; s++) begin
                mlru[s] = '0;
                for (int w = 0; w < 8; w++) begin
                    mtag[s][w] = '0; mvld[s][w] = 0; mdty[s][w] = 0;
                end
            end
            m_left = 0; m_inwb = 0; m_req = 0; m_rv = 0; m_rd = '0; m_waddr = '0;
            m_acked = 0; m_cnt = 0;
        end else begin
            logic [31:0] ta;
            int s, wsel, hw;
            bit hit, busy, ackn;
            logic [20:0] t;
            ta = op_base + {{23{op_ofs[6]}}, op_ofs, 2'b00};
            s = int'(ta[10:6]); wsel = int'(ta[13:11]); t = ta[31:11];
            hit = 0; hw = 0;
            for (int w = 7; w >= 0; w--) if (mvld[s][w] && mtag[s][w] == t) begin hit = 1; hw = w; end
            busy = m_inwb || (m_left > 0);
            m_rv = 0; m_rd = '0;
            if (op_valid && !busy && op_code == 2) begin
                m_rv = 1; m_rd = {10'b0, mvld[s][wsel], mtag[s][wsel]};
            end
            if (op_valid && !busy && op_code == 3) begin
                m_rv = 1;
                for (int w = 0; w < 8; w++) m_rd[10 + w] = mdty[s][w];
                m_rd[9:0] = mlru[s];
            end
            if (fill_valid) begin
                mtag[fill_set][fill_way] = fill_tag;
                mvld[fill_set][fill_way] = 1;
                mdty[fill_set][fill_way] = fill_dirty;
                mlru[fill_set] = ref_order(mlru[fill_set], int'(fill_way), 0);
            end
            if (m_inwb) begin
                ackn = m_req && wb_ack;
                if (ackn) begin m_req = 0; m_acked = 1; mdty[m_wset][m_wway] = 0; end
                if (m_cnt == 1 && m_acked) m_inwb = 0;
                else if (m_cnt > 1) m_cnt--;
            end else if (m_left > 0) begin
                m_left--;
            end else if (op_valid) begin
                if (op_code == 0 && hit) begin
                    mlru[s] = ref_order(mlru[s], hw, 1);
                    if (mdty[s][hw]) begin
                        m_inwb = 1; m_cnt = 19; m_acked = 0; m_req = 1;
                        m_waddr = {t, ta[10:6], 6'b0}; m_wset = s; m_wway = hw;
                    end else m_left = 4;
                end
                if (op_code == 1 && hit) begin
                    mvld[s][hw] = 0; mdty[s][hw] = 0;
                    mlru[s] = ref_order(mlru[s], hw, 1);
                    m_left = 2;
                end
                if (op_code == 3) m_left = 1;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bad = (stall !== (m_inwb || m_left > 0)) || (rd_valid !== m_rv) ||
                  (wb_req !== m_req) || (m_rv && rd_data !== m_rd) ||
                  (m_req && wb_addr !== m_waddr);
            tests++;
            if (bad) begin
                fails++;
                $display("FAIL %s: model mismatch stall=%0b/%0b rdv=%0b/%0b rd=%h/%h req=%0b/%0b addr=%h/%h",
                         cur_req, stall, (m_inwb || m_left > 0), rd_valid, m_rv, rd_data, m_rd,
                         wb_req, m_req, wb_addr, m_waddr);
            end
        end
    end

    // memory acknowledge responder
    always @(negedge clk) begin
        if (wb_ack) begin wb_ack <= 1'b0; ack_cnt <= 0; end
        else if (wb_req) begin
            if (ack_cnt >= ack_delay) wb_ack <= 1'b1;
            else ack_cnt <= ack_cnt + 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(bit ov, logic [1:0] code, logic [31:0] base, logic [6:0] ofs,
                         bit fv, logic [4:0] fs, logic [2:0] fw, logic [20:0] ft, bit fd);
        @(negedge clk);
        op_valid = ov; op_code = code; op_base = base; op_ofs = ofs;
        fill_valid = fv; fill_set = fs; fill_way = fw; fill_tag = ft; fill_dirty = fd;
        @(negedge clk);
        op_valid = 0; fill_valid = 0;
    endtask

    task automatic fill(logic [4:0] s, logic [2:0] w, logic [20:0] t, bit dt);
        issue(0, 0, 0, 0, 1, s, w, t, dt);
    endtask

    task automatic op(logic [1:0] code, logic [31:0] base, logic [6:0] ofs);
        issue(1, code, base, ofs, 0, 0, 0, 0, 0);
    endtask

    task automatic stall_len(output int n);
        n = 0;
        while (stall) begin n++; @(negedge clk); end
    endtask

    function automatic logic [31:0] la(logic [20:0] t, int s);
        return {t, 5'(s), 6'b0};
    endfunction

    function automatic logic [31:0] ra(int s, int w);
        return 32'hFFFF_C000 | (w << 11) | (s << 6);
    endfunction

    localparam logic [20:0] T1 = 21'h1ABCD, T2 = 21'h0F00F, T3 = 21'h12345,
                            T4 = 21'h00777, T5 = 21'h15555, T6 = 21'h0AAAA, T7 = 21'h03C3C;

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R11";
        check("R11", {30'b0, stall, wb_req}, 32'h0);
        op(2, ra(3, 5), 0);
        check("R11", rd_data, 32'h0);

        cur_req = "R10";
        fill(3, 5, T1, 0);
        fill(3, 2, T2, 1);
        fill(7, 0, T3, 1);

        cur_req = "R1";
        op(2, ra(3, 5) + 32'h100, 7'h40);   // offset -64 words = -256 bytes
        check("R1", rd_data, {10'b0, 1'b1, T1});
        check("R7", {31'b0, stall}, 32'h0);

        cur_req = "R8";
        op(3, ra(3, 0), 0);
        check("R8", {rd_valid, stall}, 32'h3);
        check("R8", rd_data, 32'h0000_1032);
        stall_len(n);

        cur_req = "R2";
        op(0, la(21'h00001, 3), 0);
        stall_len(n);
        check("R2", n, 0);

        cur_req = "R3";
        op(0, la(T1, 3) - 32'h4, 7'h01);
        stall_len(n);
        check("R3", n, 4);
        op(2, ra(3, 5), 0);
        check("R3", rd_data, {10'b0, 1'b1, T1});
        cur_req = "R6";
        op(3, ra(3, 0), 0);
        check("R6", rd_data, 32'h0000_1216);
        stall_len(n);

        cur_req = "R4";
        ack_delay = 0;
        op(0, la(T2, 3), 0);
        check("R4", wb_addr, la(T2, 3));
        stall_len(n);
        check("R4", n, 19);
        op(3, ra(3, 0), 0);
        check("R4", rd_data[17:10], 32'h0);
        stall_len(n);
        ack_delay = 30;
        op(0, la(T3, 7), 0);
        stall_len(n);
        check("R4", n, 31);
        op(2, ra(7, 0), 0);
        check("R4", rd_data, {10'b0, 1'b1, T3});
        ack_delay = 0;

        cur_req = "R5";
        fill(9, 4, T4, 1);
        op(1, la(T4, 9), 0);
        check("R5", {31'b0, wb_req}, 32'h0);
        stall_len(n);
        check("R5", n, 2);
        op(2, ra(9, 4), 0);
        check("R5", rd_data, {10'b0, 1'b0, T4});
        op(1, la(T4, 9), 0);
        stall_len(n);
        check("R5", n, 0);

        cur_req = "R9";
        fill(10, 1, T5, 0);
        op(0, la(T5, 10), 0);
        op(1, la(T5, 10), 0);
        stall_len(n);
        op(2, ra(10, 1), 0);
        check("R9", rd_data, {10'b0, 1'b1, T5});

        cur_req = "R10";
        fill(12, 3, T6, 1);
        issue(1, 1, la(T6, 12), 0, 1, 12, 3, T7, 0);
        stall_len(n);
        check("R10", n, 2);
        op(2, ra(12, 3), 0);
        check("R10", rd_data, {10'b0, 1'b0, T7});
        issue(1, 2, ra(12, 6), 0, 1, 12, 6, T1, 0);
        check("R10", rd_data, 32'h0);
        op(2, ra(12, 6), 0);
        check("R10", rd_data, {10'b0, 1'b1, T1});

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule